// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes onto one output line using an asynchronous character frame. A host places a character in a holding register. The engine copies that character into its own shift register and sends it. While it sends, the host can write the next character into the holding register. The engine then starts the next frame directly after the current stop bit, so no idle time falls between frames.

Two status flags report progress. The empty flag rises when the holding register has been taken. The end flag rises when the line is about to go idle with nothing queued. Each flag has an interrupt request pulse, and each pulse has its own enable. The frame format is taken from configuration inputs when a character is loaded:
- 7 or 8 data bits
- one optional bit after the data: even parity, odd parity, or a host-supplied multiprocessor marker
- one or two stop bits

An external baud generator supplies a one-cycle tick once per bit period, and every bit on the line lasts exactly one tick period. If a host write lands in the same cycle as a load decision, the load is put off, and the newly written character is the one that gets sent.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1, `end_flag` is 1, and both interrupt requests are 0.
- R2: A cycle with `wr_en` high stores `wr_data` and `wr_mpb`. From the next cycle, `empty_flag` and `end_flag` are both 0.
- R3: When the line is idle and a character is pending, the engine loads it on the next `baud_tick`. From the following cycle, `empty_flag` is 1 and `txd` carries the start bit (0).
- R4: After the start bit, the data bits follow least significant bit first. There are 8 of them when `cfg_short_data` is 0 and 7 when it is 1; in the 7-bit case, bit 7 of the character is not sent.
- R5: `cfg_extra_mode` selects the bit after the data: 0 = no bit, 1 = even parity, 2 = odd parity, 3 = multiprocessor bit. Parity covers only the configured data bits.
- R6: The multiprocessor bit sent equals the `wr_mpb` value stored with that character.
- R7: The frame ends with one stop bit (1) when `cfg_two_stop` is 0, and with two when it is 1.
- R8: The engine changes state only on a `baud_tick`, so each bit lasts exactly one tick period.
- R9: If a character is pending when the last stop bit begins, it is loaded at that moment. Its start bit follows the stop bit with no marking between them.
- R10: If nothing is pending when the last stop bit begins, `end_flag` is set at that moment. The line then stays at 1 until a new character arrives.
- R11: When `ie_empty` is 1, each load raises `irq_empty` for exactly one cycle, in the cycle `empty_flag` becomes 1. When `ie_empty` is 0, `irq_empty` stays 0.
- R12: When `ie_end` is 1, setting `end_flag` raises `irq_end` for exactly one cycle. When `ie_end` is 0, `irq_end` stays 0.
- R13: Changing any configuration input after a character is loaded does not alter that character's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Character written by the host |
| wr_mpb | input | 1 | Multiprocessor bit stored with the character |
| cfg_short_data | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_extra_mode | input | 2 | 0 none, 1 even parity, 2 odd parity, 3 multiprocessor bit |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| ie_empty | input | 1 | Enable for the data-empty request |
| ie_end | input | 1 | Enable for the transmit-end request |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register has been taken |
| end_flag | output | 1 | Transmission finished, nothing queued |
| irq_empty | output | 1 | Data-empty interrupt pulse |
| irq_end | output | 1 | Transmit-end interrupt pulse |

## Verification
The assertions check four relations on every cycle:
- the sequencer changes state only on a tick;
- a load is only requested while a character is pending;
- each interrupt pulse appears only while its flag is set;
- a host write always clears both flags.

They also check that the end flag rises only while the line is high. Only the bench scenarios can show the bit order, parity values, stop-bit counts, back-to-back framing and the effect of configuration changes in mid-frame. The bench does this by sampling the line once per bit period and comparing the result with frames it builds itself.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP
    } stx_state_e;

    typedef enum logic [1:0] {
        EXB_NONE = 2'd0,
        EXB_EVEN = 2'd1,
        EXB_ODD  = 2'd2,
        EXB_MPB  = 2'd3
    } extra_mode_e;

endpackage

// File: rtl/stx_parity.sv
module stx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              short_i,
    output logic              odd_ones_o
);
    logic [DATA_W-1:0] masked;

    // The top data bit only counts in full-width mode.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        if (g == DATA_W - 1) begin : g_top
            assign masked[g] = data_i[g] & ~short_i;
        end else begin : g_low
            assign masked[g] = data_i[g];
        end
    end

    assign odd_ones_o = ^masked;
endmodule

// File: rtl/stx_hold_ctrl.sv
module stx_hold_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_mpb_i,
    input  logic              ie_empty_i,
    input  logic              ie_end_i,
    input  logic              load_i,
    input  logic              end_set_i,
    output logic              avail_o,
    output logic [DATA_W-1:0] hold_data_o,
    output logic              hold_mpb_o,
    output logic              empty_o,
    output logic              end_o,
    output logic              irq_empty_o,
    output logic              irq_end_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              empty;
        logic              tend;
        logic              irq_e;
        logic              irq_t;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d       = hold_q;
        hold_d.irq_e = 1'b0;
        hold_d.irq_t = 1'b0;
        if (wr_en_i) begin
            // A host write takes priority over any flag update.
            hold_d.data  = wr_data_i;
            hold_d.mpb   = wr_mpb_i;
            hold_d.empty = 1'b0;
            hold_d.tend  = 1'b0;
        end else begin
            if (load_i) begin
                hold_d.empty = 1'b1;
                hold_d.irq_e = ie_empty_i;
            end
            if (end_set_i) begin
                hold_d.tend  = 1'b1;
                hold_d.irq_t = ie_end_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '{data: '0, mpb: 1'b0, empty: 1'b1, tend: 1'b1,
                        irq_e: 1'b0, irq_t: 1'b0};
        end else begin
            hold_q <= hold_d;
        end
    end

    // A load is only offered when no write competes in the same cycle.
    assign avail_o     = ~hold_q.empty & ~wr_en_i;
    assign hold_data_o = hold_q.data;
    assign hold_mpb_o  = hold_q.mpb;
    assign empty_o     = hold_q.empty;
    assign end_o       = hold_q.tend;
    assign irq_empty_o = hold_q.irq_e;
    assign irq_end_o   = hold_q.irq_t;

    // R2
    write_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (!empty_o && !end_o));

    // R3
    load_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !hold_q.empty);

    // R11
    irq_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty_o |-> empty_o);

    // R12
    irq_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end_o |-> end_o);
endmodule

// File: rtl/stx_frame_seq.sv
module stx_frame_seq
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              avail_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic              hold_mpb_i,
    input  logic              odd_ones_i,
    input  logic              cfg_short_i,
    input  logic [1:0]        cfg_extra_i,
    input  logic              cfg_two_stop_i,
    output logic              load_o,
    output logic              end_set_o,
    output logic              txd_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_BITS  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] SHORT_BITS = CNT_W'(DATA_W - 1);

    typedef struct packed {
        stx_state_e        state;
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              short_m;
        extra_mode_e       extra;
        logic              two_stop;
        logic              xbit;
        logic              stop_left;
        logic              queued;
        logic              txd;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] nbits;
    logic             xbit_new;
    logic             last_check;

    assign nbits = seq_q.short_m ? SHORT_BITS : FULL_BITS;

    // Bit after the data, from the configuration at load time.
    always_comb begin
        unique case (extra_mode_e'(cfg_extra_i))
            EXB_EVEN: xbit_new = odd_ones_i;
            EXB_ODD:  xbit_new = ~odd_ones_i;
            EXB_MPB:  xbit_new = hold_mpb_i;
            default:  xbit_new = 1'b0;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        load_o     = 1'b0;
        end_set_o  = 1'b0;
        last_check = 1'b0;
        if (tick_i) begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    seq_d.txd = 1'b1;
                    if (avail_i) begin
                        load_o      = 1'b1;
                        seq_d.state = ST_START;
                        seq_d.txd   = 1'b0;
                    end
                end
                ST_START: begin
                    seq_d.txd   = seq_q.shift[0];
                    seq_d.shift = seq_q.shift >> 1;
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.state = ST_DATA;
                end
                ST_DATA: begin
                    if (seq_q.cnt == nbits) begin
                        if (seq_q.extra != EXB_NONE) begin
                            seq_d.state = ST_EXTRA;
                            seq_d.txd   = seq_q.xbit;
                        end else begin
                            seq_d.state     = ST_STOP;
                            seq_d.txd       = 1'b1;
                            seq_d.stop_left = seq_q.two_stop;
                            last_check      = ~seq_q.two_stop;
                        end
                    end else begin
                        seq_d.txd   = seq_q.shift[0];
                        seq_d.shift = seq_q.shift >> 1;
                        seq_d.cnt   = seq_q.cnt + CNT_W'(1);
                    end
                end
                ST_EXTRA: begin
                    seq_d.state     = ST_STOP;
                    seq_d.txd       = 1'b1;
                    seq_d.stop_left = seq_q.two_stop;
                    last_check      = ~seq_q.two_stop;
                end
                ST_STOP: begin
                    if (seq_q.stop_left) begin
                        seq_d.stop_left = 1'b0;
                        last_check      = 1'b1;
                    end else if (seq_q.queued) begin
                        seq_d.queued = 1'b0;
                        seq_d.state  = ST_START;
                        seq_d.txd    = 1'b0;
                    end else begin
                        seq_d.state = ST_IDLE;
                        seq_d.txd   = 1'b1;
                    end
                end
                default: begin
                    seq_d.state = ST_IDLE;
                    seq_d.txd   = 1'b1;
                end
            endcase

            // Start of the last stop bit: queue the next character or finish.
            if (last_check) begin
                if (avail_i) begin
                    load_o       = 1'b1;
                    seq_d.queued = 1'b1;
                end else begin
                    end_set_o = 1'b1;
                end
            end

            if (load_o) begin
                seq_d.shift    = hold_data_i;
                seq_d.short_m  = cfg_short_i;
                seq_d.extra    = extra_mode_e'(cfg_extra_i);
                seq_d.two_stop = cfg_two_stop_i;
                seq_d.xbit     = xbit_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, shift: '0, cnt: '0, short_m: 1'b0,
                       extra: EXB_NONE, two_stop: 1'b0, xbit: 1'b0,
                       stop_left: 1'b0, queued: 1'b0, txd: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign txd_o = seq_q.txd;

    // R8
    state_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(seq_q.state));

    // R9
    queued_only_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.queued |-> (seq_q.state == ST_STOP));
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    input  logic              cfg_short_data,
    input  logic [1:0]        cfg_extra_mode,
    input  logic              cfg_two_stop,
    input  logic              ie_empty,
    input  logic              ie_end,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              irq_empty,
    output logic              irq_end
);
    logic              avail;
    logic              load;
    logic              end_set;
    logic              odd_ones;
    logic              hold_mpb;
    logic [DATA_W-1:0] hold_data;

    stx_hold_ctrl #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .wr_mpb_i    (wr_mpb),
        .ie_empty_i  (ie_empty),
        .ie_end_i    (ie_end),
        .load_i      (load),
        .end_set_i   (end_set),
        .avail_o     (avail),
        .hold_data_o (hold_data),
        .hold_mpb_o  (hold_mpb),
        .empty_o     (empty_flag),
        .end_o       (end_flag),
        .irq_empty_o (irq_empty),
        .irq_end_o   (irq_end)
    );

    stx_parity #(.DATA_W(DATA_W)) u_par (
        .data_i     (hold_data),
        .short_i    (cfg_short_data),
        .odd_ones_o (odd_ones)
    );

    stx_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (baud_tick),
        .avail_i        (avail),
        .hold_data_i    (hold_data),
        .hold_mpb_i     (hold_mpb),
        .odd_ones_i     (odd_ones),
        .cfg_short_i    (cfg_short_data),
        .cfg_extra_i    (cfg_extra_mode),
        .cfg_two_stop_i (cfg_two_stop),
        .load_o         (load),
        .end_set_o      (end_set),
        .txd_o          (txd)
    );

    // R10
    end_while_marking_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> txd);
endmodule

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_mpb = 1'b0;
    logic       cfg_short_data = 1'b0;
    logic [1:0] cfg_extra_mode = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_end = 1'b0;
    logic       txd, empty_flag, end_flag, irq_empty, irq_end;

    int errors = 0;
    int checks = 0;
    int n_irq_e = 0;
    int n_irq_t = 0;
    bit done = 1'b0;

    serial_tx_engine #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_mpb(wr_mpb), .cfg_short_data(cfg_short_data),
        .cfg_extra_mode(cfg_extra_mode), .cfg_two_stop(cfg_two_stop),
        .ie_empty(ie_empty), .ie_end(ie_end), .txd(txd),
        .empty_flag(empty_flag), .end_flag(end_flag),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            baud_tick = (c % TICK_DIV == 0);
        end
    end

    initial begin : irq_mon
        forever begin
            @(negedge clk);
            if (irq_empty) n_irq_e++;
            if (irq_end)   n_irq_t++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void build(input logic [7:0] d, input bit short_m, input logic [1:0] ex,
                                  input bit two, input bit mpb,
                                  output logic [31:0] bits, output int len);
        int nb = short_m ? 7 : 8;
        int idx = 1;
        bit ones = 1'b0;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bits[idx] = d[i];
            ones ^= d[i];
            idx++;
        end
        if (ex == 2'd1) begin bits[idx] = ones;  idx++; end
        if (ex == 2'd2) begin bits[idx] = ~ones; idx++; end
        if (ex == 2'd3) begin bits[idx] = mpb;   idx++; end
        idx += two ? 2 : 1;
        len = idx + 1;   // one marking bit after the frame
    endfunction

    task automatic host_write(input logic [7:0] d, input bit mpb);
        @(negedge clk);
        wr_data = d;
        wr_mpb  = mpb;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 flags cleared by write", {empty_flag, end_flag}, 2'b00);
    endtask

    task automatic grab(input int len, output logic [31:0] bits);
        int waited = 0;
        bits = '1;
        while (txd !== 1'b0 && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        bits[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (TICK_DIV) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic wait_empty();
        int w = 0;
        while (empty_flag !== 1'b1 && w < 200) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic send_one(input string req, input logic [7:0] d, input bit mpb);
        logic [31:0] exp_bits, got;
        int len;
        build(d, cfg_short_data, cfg_extra_mode, cfg_two_stop, mpb, exp_bits, len);
        host_write(d, mpb);
        wait_empty();
        check("R3 start bit with empty flag", {empty_flag, txd}, 2'b10);
        grab(len, got);
        check(req, got, exp_bits);
        check("R10 end flag after frame", end_flag, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 reset txd", txd, 1'b1);
        check("R1 reset flags", {empty_flag, end_flag}, 2'b11);
        check("R1 reset irqs", {irq_empty, irq_end}, 2'b00);
    endtask

    task automatic t_8n1();
        int e0 = n_irq_e, t0 = n_irq_t;
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd0; cfg_two_stop = 1'b0;
        ie_empty = 1'b1; ie_end = 1'b1;
        send_one("R4 8N1 frame", 8'hA5, 1'b0);
        check("R11 one empty pulse", n_irq_e - e0, 1);
        check("R12 one end pulse", n_irq_t - t0, 1);
    endtask

    task automatic t_7even();
        cfg_short_data = 1'b1; cfg_extra_mode = 2'd1; cfg_two_stop = 1'b0;
        send_one("R5 7-bit even parity", 8'hD3, 1'b0);
    endtask

    task automatic t_8odd2();
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd2; cfg_two_stop = 1'b1;
        send_one("R7 8-bit odd parity two stops", 8'h0F, 1'b0);
    endtask

    task automatic t_mpb();
        cfg_short_data = 1'b1; cfg_extra_mode = 2'd3; cfg_two_stop = 1'b0;
        send_one("R6 mpb=1", 8'h40, 1'b1);
        send_one("R6 mpb=0", 8'h7F, 1'b0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] ea, eb, got;
        logic [31:0] exp_all;
        int la, lb;
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd0; cfg_two_stop = 1'b0;
        build(8'h3C, 1'b0, 2'd0, 1'b0, 1'b0, ea, la);
        build(8'hC3, 1'b0, 2'd0, 1'b0, 1'b0, eb, lb);
        exp_all = {eb[10:0], ea[9:0]};   // R9: no marking between frames
        fork
            grab(21, got);
            begin
                host_write(8'h3C, 1'b0);
                wait_empty();
                host_write(8'hC3, 1'b0);
            end
        join
        check("R9 back-to-back frames", got & 32'h001F_FFFF, exp_all & 32'h001F_FFFF);
        check("R10 end flag after second frame", end_flag, 1'b1);
    endtask

    task automatic t_irq_off();
        int e0 = n_irq_e, t0 = n_irq_t;
        ie_empty = 1'b0; ie_end = 1'b0;
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd1; cfg_two_stop = 1'b0;
        send_one("R5 8-bit even parity", 8'h01, 1'b0);
        check("R11 no empty pulse when disabled", n_irq_e - e0, 0);
        check("R12 no end pulse when disabled", n_irq_t - t0, 0);
    endtask

    task automatic t_cfg_change();
        logic [31:0] exp_bits, got;
        int len;
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd0; cfg_two_stop = 1'b0;
        build(8'h96, 1'b0, 2'd0, 1'b0, 1'b0, exp_bits, len);
        host_write(8'h96, 1'b0);
        wait_empty();
        cfg_short_data = 1'b1; cfg_extra_mode = 2'd2; cfg_two_stop = 1'b1;
        grab(len, got);
        check("R13 frame unaffected by config change", got, exp_bits);
    endtask

    task automatic t_bit_period();
        int w = 0;
        int run = 0;
        cfg_short_data = 1'b0; cfg_extra_mode = 2'd0; cfg_two_stop = 1'b0;
        host_write(8'h00, 1'b0);
        while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
        while (txd === 1'b0 && run < 200) begin @(negedge clk); run++; end
        check("R8 start plus 8 zero bits span", run, 9 * TICK_DIV);
        repeat (2 * TICK_DIV) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_8n1();
        t_7even();
        t_8odd2();
        t_mpb();
        t_back_to_back();
        t_irq_off();
        t_cfg_change();
        t_bit_period();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule